// File: doc/BRIEF.md
# Cipher Key Store with Zeroize

This block holds the secret key for a block-cipher engine. Software or a loader writes eight 32-bit words one at a time by index, then commits a key length. A zeroize command wipes the whole bank. The bank drives the full 256-bit key, the committed length and a status bit that says the key was wiped. The key-expansion logic that uses these outputs is outside the block.

Every access is allowed only while the message sequencer reports that it is idle. While a message is in progress, a write, commit or wipe request leaves the stored key unchanged and raises a one-cycle error pulse. Each stored word is byte-reversed on the way in. When a message begins and the committed length is zero, the bank falls back to an all-zero key and reports an effective length of 256. An error is also flagged in that case.

Top module: `cipher_key_store`

## Requirements
- R1: After reset the key output is all zero, `keyLen` is 256, `engineLen` is 256, and `keyZeroed` and `errPulse` are 0.
- R2: A write with `wrIdx` below 8 while `seqIdle` is high stores `wrData` byte-reversed (byte 0 becomes byte 3) in `keyOut[32*wrIdx +: 32]`. The store is visible in the cycle after the command, and no error is raised.
- R3: A write with `wrIdx` of 8 or more raises `errPulse` in the next cycle and leaves the key output unchanged.
- R4: A write, commit or wipe request while `seqIdle` is low has no effect on `keyOut`, `keyLen` or `keyZeroed`, and raises `errPulse` in the next cycle.
- R5: A commit while idle sets `keyLen` from `lenSel` (2'b00 gives 0, 2'b01 gives 128, 2'b10 gives 256) and clears `keyZeroed`. The code 2'b11 is rejected with `errPulse`, and the length and flag are left unchanged.
- R6: A wipe while idle clears all eight words and sets `keyZeroed` in the next cycle.
- R7: `msgStart` while `keyLen` is 0 clears all words and raises `errPulse`. While `keyLen` is 0, `engineLen` reads 256. `msgStart` with a nonzero length changes nothing and raises no error. `msgStart` is not gated by `seqIdle`.
- R8: When more than one of `wrEn`, `loadEn`, `zeroEn` and `msgStart` is high in the same cycle, none of them takes effect, and `errPulse` is raised in the next cycle.
- R9: `errPulse` is high for exactly one cycle per rejected command. It is low in the cycle after that unless a further command is rejected.
- R10: A word write leaves `keyLen` and `keyZeroed` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seqIdle | input | 1 | Sequencer reports idle; gates writes, commits and wipes |
| wrEn | input | 1 | Write one key word |
| wrIdx | input | 4 | Word index for the write |
| wrData | input | 32 | Word to store (byte-reversed on entry) |
| loadEn | input | 1 | Commit a key length |
| lenSel | input | 2 | Length code: 00 zero, 01 128, 10 256, 11 illegal |
| zeroEn | input | 1 | Wipe the key bank |
| msgStart | input | 1 | A message begins; triggers the zero-length fallback |
| keyOut | output | 256 | Stored key, word i at bits 32*i+31..32*i |
| keyLen | output | 9 | Committed key length |
| engineLen | output | 9 | Length given to the engine (256 when committed length is 0) |
| keyZeroed | output | 1 | Key has been wiped and not recommitted since |
| errPulse | output | 1 | One-cycle pulse for a rejected command |

## Verification
A wrong strobe or a wrong error decision in the control shows at the ports one cycle after the command. It appears either as a key word, length or wiped flag that changed when it should have held, or as a missing or extra `errPulse`. A wrong byte order or a wrong word position shows in `keyOut` in that same cycle. The tests therefore compare the whole key, the length and the flag after every single command. The fallback path is checked both with and without a zero length, so that a missing or spurious wipe on message start is caught in the cycle right after `msgStart`.

// File: rtl/keystore_pkg.sv
package keystore_pkg;

  localparam int KS_WORDS  = 8;
  localparam int KS_WORD_W = 32;
  localparam int KS_IDX_W  = 4;
  localparam int KS_LEN_W  = 9;

  typedef enum logic [1:0] {
    LEN_NONE = 2'b00,
    LEN_128  = 2'b01,
    LEN_256  = 2'b10,
    LEN_BAD  = 2'b11
  } ks_len_e;

  // strobes issued by the control to the bank, at most one action per cycle
  typedef struct packed {
    logic                 wr;
    logic [KS_WORDS-1:0]  wordSel;
    logic [KS_WORD_W-1:0] data;
    logic                 load;
    ks_len_e              lenSel;
    logic                 wipe;
    logic                 fallback;
  } ks_strobe_t;

endpackage

// File: rtl/keystore_ctrl.sv
module keystore_ctrl
  import keystore_pkg::*;
#(
  parameter int NUM_WORDS = KS_WORDS,
  parameter int IDX_W     = KS_IDX_W,
  parameter int WORD_W    = KS_WORD_W,
  parameter int LEN_W     = KS_LEN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              seqIdle,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrData,
  input  logic              loadEn,
  input  logic [1:0]        lenSel,
  input  logic              zeroEn,
  input  logic              msgStart,
  input  logic [LEN_W-1:0]  curLen,
  output ks_strobe_t        stb,
  output logic              errPulse
);

  localparam int CMD_N = 4;

  logic [CMD_N-1:0] cmdVec;
  logic             multiCmd;
  logic             accessCmd;
  logic             idxOk;
  logic             lenOk;
  logic             lenZero;
  logic             errNext;
  logic [NUM_WORDS-1:0] sel;

  assign cmdVec    = {wrEn, loadEn, zeroEn, msgStart};
  assign multiCmd  = $countones(cmdVec) > 1;
  assign accessCmd = wrEn | loadEn | zeroEn;
  assign idxOk     = int'(wrIdx) < NUM_WORDS;
  assign lenOk     = ks_len_e'(lenSel) != LEN_BAD;
  assign lenZero   = curLen == '0;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
    assign sel[i] = int'(wrIdx) == i;
  end

  always_comb begin
    stb          = '0;
    stb.data     = wrData;
    stb.wordSel  = sel;
    stb.lenSel   = ks_len_e'(lenSel);
    if (!multiCmd) begin
      stb.wr       = wrEn & seqIdle & idxOk;
      stb.load     = loadEn & seqIdle & lenOk;
      stb.wipe     = zeroEn & seqIdle;
      stb.fallback = msgStart & lenZero;
    end
  end

  always_comb begin
    errNext = 1'b0;
    if (multiCmd) begin
      errNext = 1'b1;
    end else if (accessCmd && !seqIdle) begin
      errNext = 1'b1;
    end else if (wrEn && !idxOk) begin
      errNext = 1'b1;
    end else if (loadEn && !lenOk) begin
      errNext = 1'b1;
    end else if (msgStart && lenZero) begin
      errNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errPulse <= 1'b0;
    else       errPulse <= errNext;
  end

endmodule

// File: rtl/keystore_bank.sv
module keystore_bank
  import keystore_pkg::*;
#(
  parameter int NUM_WORDS = KS_WORDS,
  parameter int WORD_W    = KS_WORD_W,
  parameter int LEN_W     = KS_LEN_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ks_strobe_t                  stb,
  output logic [NUM_WORDS*WORD_W-1:0] keyOut,
  output logic [LEN_W-1:0]            keyLen,
  output logic [LEN_W-1:0]            engineLen,
  output logic                        keyZeroed
);

  localparam int BYTES = WORD_W / 8;
  localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(NUM_WORDS * WORD_W);
  localparam logic [LEN_W-1:0] LEN_HALF = LEN_W'(NUM_WORDS * WORD_W / 2);

  logic [WORD_W-1:0] swapped;
  logic [LEN_W-1:0]  lenValue;

  // byte reversal: input byte b lands at byte BYTES-1-b
  for (genvar b = 0; b < BYTES; b++) begin : g_swap
    assign swapped[(BYTES-1-b)*8 +: 8] = stb.data[b*8 +: 8];
  end

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic [WORD_W-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wordQ <= '0;
      end else if (stb.wipe || stb.fallback) begin
        wordQ <= '0;
      end else if (stb.wr && stb.wordSel[i]) begin
        wordQ <= swapped;
      end
    end
    assign keyOut[i*WORD_W +: WORD_W] = wordQ;
  end

  always_comb begin
    unique case (stb.lenSel)
      LEN_128: lenValue = LEN_HALF;
      LEN_256: lenValue = LEN_FULL;
      default: lenValue = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyLen    <= LEN_FULL;
      keyZeroed <= 1'b0;
    end else if (stb.load) begin
      keyLen    <= lenValue;
      keyZeroed <= 1'b0;
    end else if (stb.wipe) begin
      keyZeroed <= 1'b1;
    end
  end

  assign engineLen = (keyLen == '0) ? LEN_FULL : keyLen;

endmodule

// File: rtl/cipher_key_store.sv
module cipher_key_store
  import keystore_pkg::*;
#(
  parameter int NUM_WORDS = KS_WORDS,
  parameter int WORD_W    = KS_WORD_W,
  parameter int IDX_W     = KS_IDX_W,
  parameter int LEN_W     = KS_LEN_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        seqIdle,
  input  logic                        wrEn,
  input  logic [IDX_W-1:0]            wrIdx,
  input  logic [WORD_W-1:0]           wrData,
  input  logic                        loadEn,
  input  logic [1:0]                  lenSel,
  input  logic                        zeroEn,
  input  logic                        msgStart,
  output logic [NUM_WORDS*WORD_W-1:0] keyOut,
  output logic [LEN_W-1:0]            keyLen,
  output logic [LEN_W-1:0]            engineLen,
  output logic                        keyZeroed,
  output logic                        errPulse
);

  ks_strobe_t stb;

  keystore_ctrl #(
    .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .WORD_W(WORD_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .seqIdle  (seqIdle),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .loadEn   (loadEn),
    .lenSel   (lenSel),
    .zeroEn   (zeroEn),
    .msgStart (msgStart),
    .curLen   (keyLen),
    .stb      (stb),
    .errPulse (errPulse)
  );

  keystore_bank #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .LEN_W(LEN_W)
  ) u_bank (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .keyOut    (keyOut),
    .keyLen    (keyLen),
    .engineLen (engineLen),
    .keyZeroed (keyZeroed)
  );

endmodule

// File: rtl/cipher_key_store_chk.sv
module cipher_key_store_chk #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 32,
  parameter int IDX_W     = 4,
  parameter int LEN_W     = 9
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        seqIdle,
  input logic                        wrEn,
  input logic [IDX_W-1:0]            wrIdx,
  input logic [WORD_W-1:0]           wrData,
  input logic                        loadEn,
  input logic [1:0]                  lenSel,
  input logic                        zeroEn,
  input logic                        msgStart,
  input logic [NUM_WORDS*WORD_W-1:0] keyOut,
  input logic [LEN_W-1:0]            keyLen,
  input logic [LEN_W-1:0]            engineLen,
  input logic                        keyZeroed,
  input logic                        errPulse
);

  logic oneCmd;
  assign oneCmd = $countones({wrEn, loadEn, zeroEn, msgStart}) == 1;

  p_busy_reject_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!seqIdle && (wrEn || loadEn || zeroEn)) |=>
      (errPulse && $stable(keyOut) && $stable(keyLen) && $stable(keyZeroed)));

  p_bad_index_r3: assert property (@(posedge clk) disable iff (!rstN)
    (oneCmd && wrEn && int'(wrIdx) >= NUM_WORDS) |=> (errPulse && $stable(keyOut)));

  p_wipe_r6: assert property (@(posedge clk) disable iff (!rstN)
    (oneCmd && zeroEn && seqIdle) |=> (keyOut == '0 && keyZeroed));

  p_commit_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (oneCmd && loadEn && seqIdle && lenSel != 2'b11) |=> !keyZeroed);

  p_multi_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!oneCmd && (wrEn || loadEn || zeroEn || msgStart)) |=>
      (errPulse && $stable(keyOut) && $stable(keyLen) && $stable(keyZeroed)));

  p_engine_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    engineLen != '0);

  p_write_keeps_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (oneCmd && wrEn) |=> ($stable(keyLen) && $stable(keyZeroed)));

endmodule

bind cipher_key_store cipher_key_store_chk #(
  .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/sim_cipher_key_store.sv
module sim_cipher_key_store;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         seqIdle = 1'b1;
  logic         wrEn = 1'b0;
  logic [3:0]   wrIdx = '0;
  logic [31:0]  wrData = '0;
  logic         loadEn = 1'b0;
  logic [1:0]   lenSel = '0;
  logic         zeroEn = 1'b0;
  logic         msgStart = 1'b0;
  logic [255:0] keyOut;
  logic [8:0]   keyLen;
  logic [8:0]   engineLen;
  logic         keyZeroed;
  logic         errPulse;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] expWord [8];
  logic [8:0]  expLen;
  logic        expZ;

  always #5 clk = ~clk;

  cipher_key_store u0 (
    .clk(clk), .rstN(rstN), .seqIdle(seqIdle), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .loadEn(loadEn), .lenSel(lenSel), .zeroEn(zeroEn),
    .msgStart(msgStart), .keyOut(keyOut), .keyLen(keyLen),
    .engineLen(engineLen), .keyZeroed(keyZeroed), .errPulse(errPulse)
  );

  function automatic logic [255:0] expKey();
    logic [255:0] k;
    for (int i = 0; i < 8; i++) k[i*32 +: 32] = expWord[i];
    return k;
  endfunction

  function automatic logic [31:0] rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkState(input string req, input logic expErr);
    check(keyOut === expKey(), req, keyOut, expKey());
    check(keyLen === expLen, req, 256'(keyLen), 256'(expLen));
    check(keyZeroed === expZ, req, 256'(keyZeroed), 256'(expZ));
    check(errPulse === expErr, req, 256'(errPulse), 256'(expErr));
  endtask

  // drive at negedge, release and sample at the following negedge
  task automatic clearIn();
    wrEn = 0; loadEn = 0; zeroEn = 0; msgStart = 0; seqIdle = 1;
  endtask

  task automatic stepCmd();
    @(negedge clk);
    clearIn();
  endtask

  task automatic doWrite(input int idx, input logic [31:0] d);
    wrEn = 1; wrIdx = 4'(idx); wrData = d;
    stepCmd();
  endtask

  task automatic doLoad(input logic [1:0] code);
    loadEn = 1; lenSel = code;
    stepCmd();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) expWord[i] = '0;
    expLen = 9'd256; expZ = 0;
    checkState("R1", 0);
    check(engineLen === 9'd256, "R1", 256'(engineLen), 256'd256);
  endtask

  task automatic t_write();
    for (int i = 0; i < 8; i++) begin
      logic [31:0] d = 32'h1122_3344 + 32'(i) * 32'h0101_0101;
      doWrite(i, d);
      expWord[i] = rev(d);
      checkState("R2", 0);
    end
    check(keyOut[31:0] === 32'h4433_2211, "R2", 256'(keyOut[31:0]), 256'h44332211);
    check(keyLen === 9'd256 && !keyZeroed, "R10", 256'(keyLen), 256'd256);
  endtask

  task automatic t_badIndex();
    doWrite(8, 32'hdead_beef);
    checkState("R3", 1);
    @(negedge clk);
    checkState("R9", 0);
    doWrite(15, 32'hcafe_f00d);
    checkState("R3", 1);
  endtask

  task automatic t_busy();
    seqIdle = 0; wrEn = 1; wrIdx = 4'd2; wrData = 32'h0bad_0bad;
    stepCmd();
    checkState("R4 write", 1);
    seqIdle = 0; loadEn = 1; lenSel = 2'b01;
    stepCmd();
    checkState("R4 load", 1);
    seqIdle = 0; zeroEn = 1;
    stepCmd();
    checkState("R4 zero", 1);
    @(negedge clk);
    checkState("R9", 0);
  endtask

  task automatic t_wipe();
    zeroEn = 1;
    stepCmd();
    for (int i = 0; i < 8; i++) expWord[i] = '0;
    expZ = 1;
    checkState("R6", 0);
  endtask

  task automatic t_load();
    doLoad(2'b01);
    expLen = 9'd128; expZ = 0;
    checkState("R5 len128", 0);
    doLoad(2'b11);
    checkState("R5 bad code", 1);
    doLoad(2'b10);
    expLen = 9'd256;
    checkState("R5 len256", 0);
  endtask

  task automatic t_fallback();
    doWrite(3, 32'h0102_0304);
    expWord[3] = rev(32'h0102_0304);
    checkState("R2", 0);
    msgStart = 1;
    stepCmd();
    checkState("R7 nonzero len", 0);
    doLoad(2'b00);
    expLen = 9'd0;
    checkState("R5 len0", 0);
    check(engineLen === 9'd256, "R7", 256'(engineLen), 256'd256);
    seqIdle = 0; msgStart = 1;
    stepCmd();
    expWord[3] = '0;
    checkState("R7 fallback", 1);
  endtask

  task automatic t_multi();
    doLoad(2'b10);
    expLen = 9'd256;
    doWrite(5, 32'haabb_ccdd);
    expWord[5] = rev(32'haabb_ccdd);
    checkState("R2", 0);
    wrEn = 1; wrIdx = 4'd6; wrData = 32'h5555_aaaa; zeroEn = 1;
    stepCmd();
    checkState("R8", 1);
    loadEn = 1; lenSel = 2'b01; msgStart = 1;
    stepCmd();
    checkState("R8", 1);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_badIndex();
    t_busy();
    t_wipe();
    t_load();
    t_fallback();
    t_multi();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule